// File: doc/BRIEF.md
# Constant-Off-Time Load Current Regulator

This block regulates the load current of one H-bridge cycle by cycle. It compares a sampled current code with a limit that depends on the junction temperature. When the current reaches that limit, it asks the bridge driver to tri-state the outputs for a fixed interval. It then hands the bridge back to its commanded polarity. After every turn-on it holds a blanking window. During the window the limit comparison is ignored, so a faster short-circuit check can act first. A short-circuit hit produces a one-cycle event and holds the tri-state request until the external latch drops the bridge.

The limit is flat at a nominal code up to a knee temperature. From the knee to a trip temperature it falls linearly to a fold-back code. Above the trip temperature an over-temperature flag is raised for the latch logic. The off and blanking intervals are given in nanoseconds and converted to cycle counts from the clock frequency parameter. A minimum regulation period keeps the switching rate at or below 20 kHz.

The controller has five states:
- IDLE: the bridge is not enabled.
- BLANK: the window after a turn-on.
- ARMED: the limit is compared.
- OFF: the timed tri-state.
- SHORTED: the latched tri-state after a short.

Its transitions are:
- enable (IDLE to BLANK)
- unblank (BLANK to ARMED, once the window has run)
- trip (ARMED to OFF, when current is at or above the limit and the minimum period has elapsed)
- release (OFF to BLANK, once the off count has run)
- short (BLANK or ARMED to SHORTED)
- drop (any state to IDLE, when `bridge_on` is low)

Top module: `coff_regulator`

## Requirements
- R1: After reset, `tristate_req`, `short_evt` and `over_temp` are all 0 and the controller is in IDLE.
- R2: In ARMED, a current code at or above the active limit raises `tristate_req` on the next clock edge, provided the minimum period has elapsed. A code one below the limit does not raise it.
- R3: The timed tri-state lasts exactly OFF_CYC cycles (20 with the bench parameters). The controller then returns to BLANK with `tristate_req` low.
- R4: For BLANK_CYC cycles after each turn-on (16 with the bench parameters), a current above the limit does not raise `tristate_req`.
- R5: A current code at or above SHORT_CODE (default 1000) in BLANK or ARMED gives a `short_evt` pulse exactly one cycle long. `tristate_req` rises at the same edge and stays high while `bridge_on` stays high. The short takes priority over a limit trip.
- R6: For temperature codes at or below KNEE_CODE (default 224), the limit is NOM_CODE (default 650).
- R7: For codes between KNEE_CODE and TRIP_CODE (default 239), the limit is NOM − floor((NOM − FOLD)·(T − KNEE)/(TRIP − KNEE)), with FOLD_CODE defaulting to 400. For example, code 231 gives 534. At or above TRIP_CODE the limit is FOLD_CODE.
- R8: `over_temp` is 1 one edge after the temperature code exceeds TRIP_CODE. It is 0 at TRIP_CODE or below.
- R9: Two timed trips start at least PERIOD_CYC cycles apart (50 with the bench parameters).
- R10: When `bridge_on` is low at a clock edge, the controller enters IDLE and `tristate_req` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_on | input | 1 | Bridge enabled and not latched off |
| cur_code | input | CW | Sampled load current code |
| temp_code | input | TW | Junction temperature code |
| tristate_req | output | 1 | Request to tri-state the bridge outputs |
| short_evt | output | 1 | One-cycle short-circuit event |
| over_temp | output | 1 | Temperature above the trip code |

## Verification
The bench builds the regulator with CLK_HZ set to 1 MHz and the default nanosecond intervals. This gives an off count of 20, a blanking count of 16 and a minimum period of 50 cycles. With these values, exact interval lengths and the 50-cycle gap between two trips can be measured cycle by cycle in a short run. The threshold and temperature defaults are kept. The flat region, the interior of the fold-back ramp, both of its ends and the clamp above the trip code are therefore hit at exact codes.

// File: rtl/coff_pkg.sv
`timescale 1ns/1ps
package coff_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BLANK   = 3'd1,
        ST_ARMED   = 3'd2,
        ST_OFF     = 3'd3,
        ST_SHORTED = 3'd4
    } coff_state_e;

    function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
        longint c;
        c = (clk_hz * ns) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction
endpackage

// File: rtl/coff_fold_thr.sv
`timescale 1ns/1ps
module coff_fold_thr #(
    parameter int CW         = 10,
    parameter int TW         = 8,
    parameter int NOM_CODE   = 650,
    parameter int FOLD_CODE  = 400,
    parameter int KNEE_CODE  = 224,
    parameter int TRIP_CODE  = 239
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_code,
    output logic [CW-1:0] lim_code,
    output logic          over_temp
);
    localparam int SPAN  = TRIP_CODE - KNEE_CODE;
    localparam int DROP  = NOM_CODE - FOLD_CODE;
    localparam int PW    = CW + TW + 1;

    logic [PW-1:0] diff;
    logic [PW-1:0] prod;
    logic [PW-1:0] step;

    always_comb begin
        diff = PW'(temp_code) - PW'(KNEE_CODE);
        prod = diff * PW'(DROP);
        step = prod / PW'(SPAN);
        if (int'(temp_code) <= KNEE_CODE) begin
            lim_code = CW'(NOM_CODE);
        end else if (int'(temp_code) >= TRIP_CODE) begin
            lim_code = CW'(FOLD_CODE);
        end else begin
            lim_code = CW'(PW'(NOM_CODE) - step);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) over_temp <= 1'b0;
        else        over_temp <= (int'(temp_code) > TRIP_CODE);
    end

    // R7: limit stays inside the fold-back band
    a_r7_lim_band: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lim_code) <= NOM_CODE) && (int'(lim_code) >= FOLD_CODE));
    // R8: flag follows the temperature one edge later
    a_r8_ot_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(temp_code) > TRIP_CODE) |=> over_temp);
endmodule

// File: rtl/coff_timer.sv
`timescale 1ns/1ps
module coff_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3: without a load the count never grows
    a_r3_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/coff_regulator.sv
`timescale 1ns/1ps
module coff_regulator #(
    parameter int CLK_HZ        = 100_000_000,
    parameter int OFF_NS        = 20_000,
    parameter int BLANK_NS      = 16_500,
    parameter int MIN_PERIOD_NS = 50_000,
    parameter int CW            = 10,
    parameter int TW            = 8,
    parameter int NOM_CODE      = 650,
    parameter int FOLD_CODE     = 400,
    parameter int SHORT_CODE    = 1000,
    parameter int KNEE_CODE     = 224,
    parameter int TRIP_CODE     = 239
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bridge_on,
    input  logic [CW-1:0] cur_code,
    input  logic [TW-1:0] temp_code,
    output logic          tristate_req,
    output logic          short_evt,
    output logic          over_temp
);
    import coff_pkg::*;

    localparam int OFF_CYC    = ns_to_cycles(longint'(CLK_HZ), longint'(OFF_NS));
    localparam int BLANK_CYC  = ns_to_cycles(longint'(CLK_HZ), longint'(BLANK_NS));
    localparam int PERIOD_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(MIN_PERIOD_NS));
    localparam int TMAX       = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int TCW        = $clog2(TMAX + 1);
    localparam int PCW        = $clog2(PERIOD_CYC + 1);
    localparam logic [TCW-1:0] OFF_LD   = TCW'(OFF_CYC - 1);
    localparam logic [TCW-1:0] BLANK_LD = TCW'(BLANK_CYC - 1);
    localparam logic [PCW-1:0] PER_OK   = PCW'(PERIOD_CYC - 1);

    coff_state_e      state_q, state_d;
    logic             tmr_load;
    logic [TCW-1:0]   tmr_val;
    logic             tmr_zero;
    logic [CW-1:0]    lim_code;
    logic             lim_hit, short_hit, per_ok;
    logic             short_d, short_q;
    logic [PCW-1:0]   per_q;

    coff_fold_thr #(
        .CW(CW), .TW(TW), .NOM_CODE(NOM_CODE), .FOLD_CODE(FOLD_CODE),
        .KNEE_CODE(KNEE_CODE), .TRIP_CODE(TRIP_CODE)
    ) u_thr (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
        .lim_code(lim_code), .over_temp(over_temp)
    );

    coff_timer #(.W(TCW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    assign lim_hit   = (cur_code >= lim_code);
    assign short_hit = (int'(cur_code) >= SHORT_CODE);
    assign per_ok    = (per_q >= PER_OK);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = BLANK_LD;
        short_d  = 1'b0;
        if (!bridge_on) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d  = ST_BLANK;
                    tmr_load = 1'b1;
                end
                ST_BLANK: begin
                    if (short_hit) begin
                        state_d = ST_SHORTED;
                        short_d = 1'b1;
                    end else if (tmr_zero) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (short_hit) begin
                        state_d = ST_SHORTED;
                        short_d = 1'b1;
                    end else if (lim_hit && per_ok) begin
                        state_d  = ST_OFF;
                        tmr_load = 1'b1;
                        tmr_val  = OFF_LD;
                    end
                end
                ST_OFF: begin
                    if (tmr_zero) begin
                        state_d  = ST_BLANK;
                        tmr_load = 1'b1;
                    end
                end
                ST_SHORTED: state_d = ST_SHORTED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register and period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            short_q <= 1'b0;
            per_q   <= PER_OK;
        end else begin
            state_q <= state_d;
            short_q <= short_d;
            if (state_d == ST_OFF && state_q != ST_OFF) per_q <= '0;
            else if (per_q < PER_OK)                    per_q <= per_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tristate_req = (state_q == ST_OFF) || (state_q == ST_SHORTED);
        short_evt    = short_q;
    end

    // observer for the switching-rate limit
    logic           tri_prev;
    logic [PCW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tri_prev <= 1'b0;
            gap_q    <= PER_OK;
        end else begin
            tri_prev <= tristate_req;
            if (tristate_req && !tri_prev && !short_evt) gap_q <= '0;
            else if (gap_q < PER_OK)                     gap_q <= gap_q + 1'b1;
        end
    end

    // R9: timed trips are spaced by the minimum period
    a_r9_min_period: assert property (@(posedge clk) disable iff (!rst_n)
        (tristate_req && !tri_prev && !short_evt) |-> (gap_q >= PER_OK));
    // R4: the limit never trips straight out of blanking
    a_r4_blank_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |=> (state_q != ST_OFF));
    // R5: short event is a single-cycle pulse with the tri-state held
    a_r5_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        short_evt |=> !short_evt);
    a_r5_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
        short_evt |-> tristate_req);
    // R10: dropping the bridge idles the controller
    a_r10_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_on |=> (state_q == ST_IDLE) && !tristate_req);
    // R3: the off interval ends only in blanking
    a_r3_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && bridge_on) |=> (state_q == ST_OFF || state_q == ST_BLANK));
endmodule

// File: tb/coff_regulator_bench.sv
`timescale 1ns/1ps
module coff_regulator_bench;
    localparam int CW = 10;
    localparam int TW = 8;
    localparam int NV = 10;

    localparam int V_T    [NV] = '{100, 100, 224, 224, 231, 231, 239, 239, 245, 245};
    localparam int V_I    [NV] = '{649, 650, 649, 650, 533, 534, 399, 400, 399, 400};
    localparam int V_TRIP [NV] = '{0,   1,   0,   1,   0,   1,   0,   1,   0,   1};
    localparam int V_OT   [NV] = '{0,   0,   0,   0,   0,   0,   0,   0,   1,   1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bridge_on = 1'b0;
    logic [CW-1:0] cur_code = '0;
    logic [TW-1:0] temp_code = 8'd100;
    logic          tristate_req, short_evt, over_temp;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    coff_regulator #(.CLK_HZ(1_000_000)) u_coff_regulator (
        .clk(clk), .rst_n(rst_n), .bridge_on(bridge_on),
        .cur_code(cur_code), .temp_code(temp_code),
        .tristate_req(tristate_req), .short_evt(short_evt), .over_temp(over_temp)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int idx, hi, rise2;
        wait_n(3);
        // R1: reset state
        check("R1 tristate", int'(tristate_req), 0);
        check("R1 short", int'(short_evt), 0);
        check("R1 over_temp", int'(over_temp), 0);
        rst_n = 1'b1;
        wait_n(2);

        // R4/R2/R3/R9: over-limit current from turn-on
        bridge_on = 1'b1;
        cur_code  = 10'd900;
        idx = 0;
        hi = 0;
        for (int i = 1; i <= 17; i++) begin
            @(negedge clk);
            idx++;
            if (tristate_req) hi++;
        end
        check("R4 no trip during blanking", hi, 0);
        @(negedge clk);
        idx++;
        check("R2 trip after blanking", int'(tristate_req), 1);
        hi = 0;
        while (tristate_req && idx < 200) begin
            hi++;
            @(negedge clk);
            idx++;
        end
        check("R3 off length", hi, 20);
        check("R3 released", int'(tristate_req), 0);
        while (!tristate_req && idx < 300) begin
            @(negedge clk);
            idx++;
        end
        rise2 = idx;
        check("R9 trip spacing", rise2 - 18, 50);

        // R10: drop during OFF
        bridge_on = 1'b0;
        @(negedge clk);
        check("R10 drop clears tristate", int'(tristate_req), 0);

        // R5: short during blanking
        cur_code  = '0;
        bridge_on = 1'b1;
        wait_n(3);
        cur_code = 10'd1000;
        @(negedge clk);
        check("R5 short pulse", int'(short_evt), 1);
        check("R5 short tristate", int'(tristate_req), 1);
        cur_code = '0;
        @(negedge clk);
        check("R5 pulse one cycle", int'(short_evt), 0);
        wait_n(5);
        check("R5 tristate held", int'(tristate_req), 1);
        bridge_on = 1'b0;
        @(negedge clk);
        check("R10 short released", int'(tristate_req), 0);

        // R5: short beats limit in ARMED
        bridge_on = 1'b1;
        wait_n(17);
        cur_code = 10'd1000;
        @(negedge clk);
        check("R5 short priority", int'(short_evt), 1);
        cur_code  = '0;
        bridge_on = 1'b0;
        wait_n(2);

        // R2/R6/R7/R8: threshold vectors
        for (int v = 0; v < NV; v++) begin
            temp_code = TW'(V_T[v]);
            cur_code  = '0;
            bridge_on = 1'b0;
            @(negedge clk);
            bridge_on = 1'b1;
            wait_n(17 + 50);
            check((V_T[v] > 239) ? "R8 over_temp high" : "R8 over_temp low",
                  int'(over_temp), V_OT[v]);
            cur_code = CW'(V_I[v]);
            @(negedge clk);
            if (V_T[v] <= 224)      check("R6 flat limit", int'(tristate_req), V_TRIP[v]);
            else if (V_T[v] < 239)  check("R7 fold ramp", int'(tristate_req), V_TRIP[v]);
            else                    check("R7 fold clamp", int'(tristate_req), V_TRIP[v]);
        end
        bridge_on = 1'b0;
        cur_code  = '0;
        wait_n(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule